// File: doc/BRIEF.md
# SPI Transmit Chunk Deframer

This block sits on the device side of a chunked, full-duplex SPI data link. A deserializer in front of it delivers the MOSI traffic as bytes, one per `in_valid`, and marks the first byte of every chunk with `in_first`. A chunk is a 32-bit header, sent most significant byte first, followed by a fixed 64-byte payload. The header carries odd parity, a data/control flag, a sequence toggle, a no-receive request, a payload-valid flag and two frame-boundary descriptors. The start descriptor is a 32-bit word offset and the end descriptor is the offset of the last frame byte. The header also carries a 2-bit timestamp-capture code.

The block checks each header and keeps the payload only when the header is good. It then picks out the bytes that belong to a frame and emits them as a byte stream with start and end markers and the frame's timestamp code. A frame may span any number of chunks. One chunk may close one frame and open the next. The sequence and no-receive bits go to neighbouring logic with a strobe. Header parity errors and writes made while the transmit credit count is zero are raised as one-cycle flags.

Top module: `txchunk_deframer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `out_valid`, `out_sof`, `out_eof`, `hdr_done`, `hdr_bad` and `credit_err` are all 0.
- R2: The header is taken from chunk bytes 0..3, most significant byte first. The total number of ones in the 32 bits must be odd. If it is not, `hdr_bad` pulses together with `hdr_done` and the payload of that chunk is discarded without changing whether a frame is open.
- R3: A header whose bit 31 (data flag) is 0, or whose bit 21 (payload valid) is 0, causes its whole payload to be discarded.
- R4: One cycle after the last header byte is accepted, `hdr_done` pulses. From then on `seq_bit` holds header bit 30 and `norx_req` holds header bit 29.
- R5: When bit 20 (start) is set, a frame begins at payload byte 4×bits[19:16]. That byte is emitted with `out_sof`.
- R6: When bit 14 (end) is set and a frame is open, the frame's last byte is payload byte bits[13:8]. It is emitted with `out_eof`, and no later byte of the chunk is emitted unless a new frame starts there. An end with no frame open emits nothing.
- R7: When start and end are both set and the end offset lies before the start byte, bytes 0..end finish the open frame with `out_eof`, bytes between are dropped, and a new frame starts at the start byte.
- R8: When neither start nor end is set, all 64 payload bytes continue an open frame. If no frame is open, they are dropped.
- R9: `out_tsc` carries bits[7:6] of the header that started the frame, on every byte of that frame. The codes of later headers are ignored until the next start.
- R10: A chunk that passes R2 and R3 while `tx_credits` is 0 pulses `credit_err` with `hdr_done` and its payload is discarded.
- R11: `in_first` restarts the chunk at header byte 0 even in the middle of a chunk. Bytes arriving after byte 67 without a new `in_first` are ignored.
- R12: A start in a chunk while a frame is open, and not preceded by an end in that chunk, abandons the open frame. Payload bytes before the start byte are dropped, and the new frame begins with `out_sof` and no `out_eof` for the old one.
- R13: Each accepted payload byte appears on `out_byte` one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A MOSI byte is presented this cycle |
| in_first | input | 1 | The presented byte is byte 0 of a chunk |
| in_byte | input | 8 | Deserialized MOSI byte |
| tx_credits | input | 5 | Transmit chunks the buffer can still take |
| out_valid | output | 1 | A frame byte is presented |
| out_byte | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_tsc | output | 2 | Timestamp-capture code of the current frame |
| hdr_done | output | 1 | One-cycle strobe: a header was completed |
| hdr_bad | output | 1 | One-cycle flag: header parity was wrong |
| norx_req | output | 1 | No-receive request of the last header |
| seq_bit | output | 1 | Sequence toggle of the last header |
| credit_err | output | 1 | One-cycle flag: valid chunk written with no credit |

## Verification
The assertions assume that `in_first` is raised only together with `in_valid`. They also assume that `tx_credits` is stable across a header, so the credit flag can be related to the previous cycle's count. The bench drives every byte with `in_valid` high, sets `in_first` only on a chunk's first byte, and changes the credit count only between chunks with the input idle. The frame-tracking assertions watch only the output markers, so they stay valid under the truncated chunks and stray bytes the bench injects.

// File: rtl/txd_pkg.sv
// Shared definitions for the transmit chunk deframer.
// Assumes the 32-bit header layout below; field positions are decoded by
// neighbouring logic and must not move.
package txd_pkg;

    localparam int HDR_BYTES = 4;
    localparam int PAY_BYTES = 64;
    localparam int HDR_W     = HDR_BYTES * 8;

    typedef struct packed {
        logic       is_data;     // 31
        logic       seq;         // 30
        logic       norx;        // 29
        logic [4:0] rsv_a;       // 28:24
        logic [1:0] vendor;      // 23:22
        logic       pay_ok;      // 21
        logic       has_start;   // 20
        logic [3:0] start_word;  // 19:16
        logic       rsv_b;       // 15
        logic       has_end;     // 14
        logic [5:0] end_byte;    // 13:8
        logic [1:0] ts_code;     // 7:6
        logic [4:0] rsv_c;       // 5:1
        logic       par;         // 0
    } txd_hdr_t;

    // Odd parity holds when the header contains an odd number of ones.
    function automatic logic txd_parity_ok(input logic [HDR_W-1:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/txd_chunk_cursor.sv
// Tracks the byte position inside a chunk.
// Assumes in_first is only raised with in_valid. Assembles the header
// (MSB first) and presents payload bytes with their index. Bytes past the
// chunk end are ignored until the next chunk marker.
module txd_chunk_cursor #(
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 64,
    localparam int CHUNK    = HDR_BYTES + PAY_BYTES,
    localparam int POS_W    = $clog2(CHUNK + 1),
    localparam int IDX_W    = $clog2(PAY_BYTES),
    localparam int HDR_W    = HDR_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [7:0]       in_byte,
    output logic             hdr_last,
    output logic [HDR_W-1:0] hdr_word,
    output logic             pay_valid,
    output logic [IDX_W-1:0] pay_idx,
    output logic [7:0]       pay_byte
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur;
    logic [HDR_W-9:0] shift_q;
    logic             in_chunk;

    // Position of the byte presented this cycle.
    always_comb begin
        cur      = in_first ? '0 : pos_q;
        in_chunk = cur < POS_W'(CHUNK);
    end

    // Advance position and collect leading header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= POS_W'(CHUNK);
            shift_q <= '0;
        end else if (in_valid && in_chunk) begin
            pos_q <= cur + POS_W'(1);
            if (cur < POS_W'(HDR_BYTES - 1))
                shift_q <= {shift_q[HDR_W-17:0], in_byte};
        end
    end

    // Present completed header and payload bytes.
    always_comb begin
        hdr_last  = in_valid && in_chunk && (cur == POS_W'(HDR_BYTES - 1));
        hdr_word  = {shift_q, in_byte};
        pay_valid = in_valid && in_chunk && (cur >= POS_W'(HDR_BYTES));
        pay_idx   = IDX_W'(cur - POS_W'(HDR_BYTES));
        pay_byte  = in_byte;
    end

endmodule

// File: rtl/txd_chunk_gate.sv
// Judges a completed header: parity, data flag, payload-valid flag and
// credit availability. Holds the boundary descriptors of the chunk in
// progress and raises the per-header strobes.
// Assumes tx_credits is stable while a header is received.
module txd_chunk_gate #(
    parameter int CREDIT_W = 5,
    parameter int HDR_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_last,
    input  logic [HDR_W-1:0]     hdr_word,
    input  logic [CREDIT_W-1:0]  tx_credits,
    output logic                 accept,
    output txd_pkg::txd_hdr_t    hdr_q,
    output logic                 hdr_done,
    output logic                 hdr_bad,
    output logic                 credit_err
);
    import txd_pkg::*;

    txd_hdr_t h;
    logic     par_good;
    logic     wants_data;
    logic     no_credit;

    // Decode the incoming header word.
    always_comb begin
        h          = txd_hdr_t'(hdr_word);
        par_good   = txd_parity_ok(hdr_word);
        wants_data = par_good && h.is_data && h.pay_ok;
        no_credit  = (tx_credits == '0);
    end

    // Register the verdict and the descriptors when a header completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept     <= 1'b0;
            hdr_q      <= '0;
            hdr_done   <= 1'b0;
            hdr_bad    <= 1'b0;
            credit_err <= 1'b0;
        end else begin
            hdr_done   <= hdr_last;
            hdr_bad    <= hdr_last && !par_good;
            credit_err <= hdr_last && wants_data && no_credit;
            if (hdr_last) begin
                accept <= wants_data && !no_credit;
                hdr_q  <= h;
            end
        end
    end

endmodule

// File: rtl/txd_frame_pick.sv
// Selects frame bytes from an accepted payload using the start word offset
// and end byte offset. Keeps the open-frame state across chunks and the
// timestamp code of the frame in progress.
// Assumes descriptors are stable for the whole payload of a chunk.
module txd_frame_pick #(
    parameter int PAY_BYTES = 64,
    parameter int SWO_W     = 4,
    localparam int IDX_W    = $clog2(PAY_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pay_valid,
    input  logic [IDX_W-1:0] pay_idx,
    input  logic [7:0]       pay_byte,
    input  logic             accept,
    input  logic             has_start,
    input  logic [SWO_W-1:0] start_word,
    input  logic             has_end,
    input  logic [IDX_W-1:0] end_byte,
    input  logic [1:0]       ts_code,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sof,
    output logic             out_eof,
    output logic [1:0]       out_tsc
);

    logic             open_q;
    logic [1:0]       tsc_q;
    logic [IDX_W-1:0] start_idx;
    logic             end_first;
    logic             sof_here;
    logic             eof_here;
    logic             skip_old;
    logic             take;

    // Classify the current payload byte.
    always_comb begin
        start_idx = IDX_W'({start_word, 2'b00});
        end_first = has_start && has_end && (end_byte < start_idx);
        sof_here  = has_start && (pay_idx == start_idx);
        eof_here  = has_end && (pay_idx == end_byte);
        skip_old  = has_start && !end_first && (pay_idx < start_idx);
        take      = pay_valid && accept && ((open_q && !skip_old) || sof_here);
    end

    // Emit the byte and update the frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_tsc   <= '0;
            open_q    <= 1'b0;
            tsc_q     <= '0;
        end else begin
            out_valid <= take;
            out_sof   <= take && sof_here;
            out_eof   <= take && eof_here;
            if (take) begin
                out_byte <= pay_byte;
                out_tsc  <= sof_here ? ts_code : tsc_q;
                open_q   <= !eof_here;
                if (sof_here)
                    tsc_q <= ts_code;
            end
        end
    end

endmodule

// File: rtl/txchunk_deframer.sv
// Device-side deframer for transmit chunks arriving over SPI.
// Assumes a byte stream with a chunk marker on byte 0; emits frame bytes
// with start/end markers and reports per-header status.
module txchunk_deframer #(
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 64,
    parameter int CREDIT_W  = 5,
    localparam int IDX_W    = $clog2(PAY_BYTES),
    localparam int HDR_W    = HDR_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic [7:0]          in_byte,
    input  logic [CREDIT_W-1:0] tx_credits,
    output logic                out_valid,
    output logic [7:0]          out_byte,
    output logic                out_sof,
    output logic                out_eof,
    output logic [1:0]          out_tsc,
    output logic                hdr_done,
    output logic                hdr_bad,
    output logic                norx_req,
    output logic                seq_bit,
    output logic                credit_err
);
    import txd_pkg::*;

    logic             hdr_last;
    logic [HDR_W-1:0] hdr_word;
    logic             pay_valid;
    logic [IDX_W-1:0] pay_idx;
    logic [7:0]       pay_byte;
    logic             accept;
    txd_hdr_t         hdr_q;

    txd_chunk_cursor #(
        .HDR_BYTES (HDR_BYTES),
        .PAY_BYTES (PAY_BYTES)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_byte   (in_byte),
        .hdr_last  (hdr_last),
        .hdr_word  (hdr_word),
        .pay_valid (pay_valid),
        .pay_idx   (pay_idx),
        .pay_byte  (pay_byte)
    );

    txd_chunk_gate #(
        .CREDIT_W (CREDIT_W),
        .HDR_W    (HDR_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_last   (hdr_last),
        .hdr_word   (hdr_word),
        .tx_credits (tx_credits),
        .accept     (accept),
        .hdr_q      (hdr_q),
        .hdr_done   (hdr_done),
        .hdr_bad    (hdr_bad),
        .credit_err (credit_err)
    );

    txd_frame_pick #(
        .PAY_BYTES (PAY_BYTES),
        .SWO_W     (4)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .pay_valid  (pay_valid),
        .pay_idx    (pay_idx),
        .pay_byte   (pay_byte),
        .accept     (accept),
        .has_start  (hdr_q.has_start),
        .start_word (hdr_q.start_word),
        .has_end    (hdr_q.has_end),
        .end_byte   (IDX_W'(hdr_q.end_byte)),
        .ts_code    (hdr_q.ts_code),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_sof    (out_sof),
        .out_eof    (out_eof),
        .out_tsc    (out_tsc)
    );

    // Forward sideband bits of the last header.
    always_comb begin
        norx_req = hdr_q.norx;
        seq_bit  = hdr_q.seq;
    end

endmodule

// File: rtl/txchunk_deframer_chk.sv
// Property checker for the transmit chunk deframer, bound to the top.
// Tracks frame state from the output markers only.
module txchunk_deframer_chk #(
    parameter int CREDIT_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [CREDIT_W-1:0] tx_credits,
    input logic                out_valid,
    input logic                out_sof,
    input logic                out_eof,
    input logic [1:0]          out_tsc,
    input logic                hdr_done,
    input logic                hdr_bad,
    input logic                credit_err
);

    logic       trk_open;
    logic [1:0] trk_tsc;

    // Follow the frame state as seen at the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_open <= 1'b0;
            trk_tsc  <= '0;
        end else if (out_valid) begin
            trk_open <= !out_eof;
            if (out_sof)
                trk_tsc <= out_tsc;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !hdr_done && !hdr_bad && !credit_err);

    // R5
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R6
    eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R8
    inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sof |-> trk_open);

    // R9
    tsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sof |-> out_tsc == trk_tsc);

    // R2
    bad_with_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_bad |-> hdr_done && !credit_err);

    // R10
    credit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credit_err |-> hdr_done && ($past(tx_credits) == '0));

    // R13
    byte_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

bind txchunk_deframer txchunk_deframer_chk #(.CREDIT_W(CREDIT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .tx_credits (tx_credits),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_tsc    (out_tsc),
    .hdr_done   (hdr_done),
    .hdr_bad    (hdr_bad),
    .credit_err (credit_err)
);

// File: tb/txchunk_deframer_tb.sv
// Directed bench for the transmit chunk deframer.
module txchunk_deframer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic [7:0] in_byte = '0;
    logic [4:0] tx_credits = 5'd8;
    logic       out_valid, out_sof, out_eof;
    logic [7:0] out_byte;
    logic [1:0] out_tsc;
    logic       hdr_done, hdr_bad, norx_req, seq_bit, credit_err;

    always #10 clk = ~clk;

    txchunk_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_byte(in_byte), .tx_credits(tx_credits), .out_valid(out_valid),
        .out_byte(out_byte), .out_sof(out_sof), .out_eof(out_eof),
        .out_tsc(out_tsc), .hdr_done(hdr_done), .hdr_bad(hdr_bad),
        .norx_req(norx_req), .seq_bit(seq_bit), .credit_err(credit_err)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [7:0] got_b [256];
    logic       got_s [256];
    logic       got_e [256];
    logic [1:0] got_t [256];
    int         got_n = 0;
    logic [7:0] exp_b [256];
    logic       exp_s [256];
    logic       exp_e [256];
    logic [1:0] exp_t [256];
    int         exp_n = 0;
    int         hdr_cnt = 0, bad_cnt = 0, ovf_cnt = 0;
    logic       hs_seq [64];
    logic       hs_norx [64];

    // Record outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && got_n < 256) begin
                got_b[got_n] = out_byte; got_s[got_n] = out_sof;
                got_e[got_n] = out_eof;  got_t[got_n] = out_tsc;
                got_n++;
            end
            if (hdr_done) begin
                if (hdr_cnt < 64) begin
                    hs_seq[hdr_cnt] = seq_bit; hs_norx[hdr_cnt] = norx_req;
                end
                hdr_cnt++;
                if (hdr_bad) bad_cnt++;
            end
            if (credit_err) ovf_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input bit dnc, input bit seq,
        input bit norx, input bit dv, input bit sv, input logic [3:0] swo,
        input bit ev, input logic [5:0] ebo, input logic [1:0] tsc,
        input bit badpar);
        logic [31:0] w;
        w = {dnc, seq, norx, 5'b0, 2'b0, dv, sv, swo, 1'b0, ev, ebo, tsc, 5'b0, 1'b0};
        w[0] = ~(^w[31:1]);
        if (badpar) w[0] = ~w[0];
        return w;
    endfunction

    task automatic put_byte(input logic [7:0] b, input bit first);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_first = first;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Header MSB first, then npay payload bytes {tag, index}.
    task automatic send_chunk(input logic [31:0] h, input logic [1:0] tag,
                              input int npay);
        for (int i = 0; i < 4; i++) put_byte(h[31-8*i -: 8], i == 0);
        for (int i = 0; i < npay; i++) put_byte({tag, 6'(i)}, 1'b0);
        idle(2);
    endtask

    task automatic exp_add(input logic [1:0] tag, input int lo, input int hi,
                           input bit sof, input bit eof, input logic [1:0] tsc);
        for (int i = lo; i <= hi; i++) begin
            exp_b[exp_n] = {tag, 6'(i)};
            exp_s[exp_n] = sof && (i == lo);
            exp_e[exp_n] = eof && (i == hi);
            exp_t[exp_n] = tsc;
            exp_n++;
        end
    endtask

    task automatic check_stream(input string req);
        chk(got_n == exp_n, req, "byte count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_b[i] == exp_b[i] && got_s[i] == exp_s[i] &&
                got_e[i] == exp_e[i] && got_t[i] == exp_t[i], req,
                $sformatf("entry %0d {byte,sof,eof,tsc}", i),
                int'({got_b[i], got_s[i], got_e[i], got_t[i]}),
                int'({exp_b[i], exp_s[i], exp_e[i], exp_t[i]}));
        end
        got_n = 0; exp_n = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sof && !out_eof && !hdr_done && !hdr_bad && !credit_err,
            "R1", "outputs in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !hdr_done && !credit_err, "R1", "outputs after release",
            int'(out_valid), 0);
    endtask

    task automatic t_single;
        send_chunk(mk_hdr(1,0,0,1,1,4'd2,1,6'd20,2'd2,0), 2'd1, 64);
        exp_add(2'd1, 8, 20, 1, 1, 2'd2);
        check_stream("R5 R6 R13 frame in one chunk");
        send_chunk(mk_hdr(1,0,0,1,1,4'd1,1,6'd4,2'd0,0), 2'd2, 64);
        exp_add(2'd2, 4, 4, 1, 1, 2'd0);
        check_stream("R5 R6 single byte frame");
    endtask

    task automatic t_multi;
        int h0;
        h0 = hdr_cnt;
        send_chunk(mk_hdr(1,0,0,1,1,4'd0,0,6'd0,2'd1,0), 2'd0, 64);
        send_chunk(mk_hdr(1,1,1,1,0,4'd0,0,6'd0,2'd3,0), 2'd1, 64);
        send_chunk(mk_hdr(1,0,0,1,0,4'd0,1,6'd5,2'd0,0), 2'd2, 64);
        exp_add(2'd0, 0, 63, 1, 0, 2'd1);
        exp_add(2'd1, 0, 63, 0, 0, 2'd1);
        exp_add(2'd2, 0, 5, 0, 1, 2'd1);
        check_stream("R8 R9 three-chunk frame");
        chk(hdr_cnt - h0 == 3, "R4", "header strobes", hdr_cnt - h0, 3);
        chk(hs_seq[h0] == 0 && hs_norx[h0] == 0, "R4", "seq/norx chunk A",
            int'({hs_seq[h0], hs_norx[h0]}), 0);
        chk(hs_seq[h0+1] == 1 && hs_norx[h0+1] == 1, "R4", "seq/norx chunk B",
            int'({hs_seq[h0+1], hs_norx[h0+1]}), 3);
        chk(hs_seq[h0+2] == 0 && hs_norx[h0+2] == 0, "R4", "seq/norx chunk C",
            int'({hs_seq[h0+2], hs_norx[h0+2]}), 0);
    endtask

    task automatic t_no_frame;
        send_chunk(mk_hdr(1,0,0,1,0,4'd0,0,6'd0,2'd0,0), 2'd0, 64);
        check_stream("R8 continuation without open frame");
        send_chunk(mk_hdr(1,0,0,1,0,4'd0,1,6'd7,2'd0,0), 2'd1, 64);
        check_stream("R6 end without open frame");
    endtask

    task automatic t_end_then_start;
        send_chunk(mk_hdr(1,0,0,1,1,4'd15,0,6'd0,2'd0,0), 2'd0, 64);
        send_chunk(mk_hdr(1,0,0,1,1,4'd4,1,6'd3,2'd3,0), 2'd1, 64);
        send_chunk(mk_hdr(1,0,0,1,0,4'd0,1,6'd0,2'd0,0), 2'd2, 64);
        exp_add(2'd0, 60, 63, 1, 0, 2'd0);
        exp_add(2'd1, 0, 3, 0, 1, 2'd0);
        exp_add(2'd1, 16, 63, 1, 0, 2'd3);
        exp_add(2'd2, 0, 0, 0, 1, 2'd3);
        check_stream("R7 end before start in one chunk");
    endtask

    task automatic t_parity;
        int b0;
        b0 = bad_cnt;
        send_chunk(mk_hdr(1,0,0,1,1,4'd0,0,6'd0,2'd0,0), 2'd0, 64);
        send_chunk(mk_hdr(1,0,0,1,0,4'd0,1,6'd9,2'd0,1), 2'd1, 64);
        send_chunk(mk_hdr(1,0,0,1,0,4'd0,1,6'd1,2'd0,0), 2'd2, 64);
        exp_add(2'd0, 0, 63, 1, 0, 2'd0);
        exp_add(2'd2, 0, 1, 0, 1, 2'd0);
        check_stream("R2 bad parity chunk discarded");
        chk(bad_cnt - b0 == 1, "R2", "header-bad pulses", bad_cnt - b0, 1);
    endtask

    task automatic t_invalid;
        send_chunk(mk_hdr(1,0,0,0,1,4'd0,1,6'd10,2'd0,0), 2'd0, 64);
        check_stream("R3 payload-valid clear");
        send_chunk(mk_hdr(0,0,0,1,1,4'd0,1,6'd10,2'd0,0), 2'd1, 64);
        check_stream("R3 data flag clear");
    endtask

    task automatic t_credit;
        int o0;
        o0 = ovf_cnt;
        tx_credits = 5'd0;
        send_chunk(mk_hdr(1,0,0,1,1,4'd0,1,6'd3,2'd0,0), 2'd0, 64);
        check_stream("R10 chunk with no credit discarded");
        chk(ovf_cnt - o0 == 1, "R10", "credit error pulses", ovf_cnt - o0, 1);
        send_chunk(mk_hdr(1,0,0,0,0,4'd0,0,6'd0,2'd0,0), 2'd1, 64);
        chk(ovf_cnt - o0 == 1, "R10", "empty chunk raises no credit error", ovf_cnt - o0, 1);
        tx_credits = 5'd1;
        send_chunk(mk_hdr(1,0,0,1,1,4'd0,1,6'd3,2'd0,0), 2'd2, 64);
        exp_add(2'd2, 0, 3, 1, 1, 2'd0);
        check_stream("R10 chunk accepted with credit");
        chk(ovf_cnt - o0 == 1, "R10", "no error with credit", ovf_cnt - o0, 1);
        tx_credits = 5'd8;
    endtask

    task automatic t_restart;
        send_chunk(mk_hdr(1,0,0,1,1,4'd0,1,6'd63,2'd0,0), 2'd0, 10);
        send_chunk(mk_hdr(1,0,0,1,1,4'd0,1,6'd2,2'd1,0), 2'd1, 64);
        exp_add(2'd0, 0, 9, 1, 0, 2'd0);
        exp_add(2'd1, 0, 2, 1, 1, 2'd1);
        check_stream("R11 marker restarts chunk");
        for (int i = 0; i < 20; i++) put_byte(8'hA5, 1'b0);
        idle(2);
        check_stream("R11 stray bytes ignored");
    endtask

    task automatic t_abandon;
        send_chunk(mk_hdr(1,0,0,1,1,4'd15,0,6'd0,2'd0,0), 2'd0, 64);
        send_chunk(mk_hdr(1,0,0,1,1,4'd1,1,6'd10,2'd2,0), 2'd1, 64);
        exp_add(2'd0, 60, 63, 1, 0, 2'd0);
        exp_add(2'd1, 4, 10, 1, 1, 2'd2);
        check_stream("R12 start abandons open frame");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_no_frame();
        t_end_then_start();
        t_parity();
        t_invalid();
        t_credit();
        t_restart();
        t_abandon();
        idle(4);
        summary();
    end

endmodule